// File: doc/BRIEF.md
# Pointer Swap Unit With Split Post-Modify

This block carries out one compound memory access through a pointer register. It reads a 16-bit word at the address held in the selected pointer and puts it into one half of a 32-bit Y value. It then writes the previous contents of that half back to memory through the same pointer. The pointer is changed twice. The first change uses one encoding and takes effect between the read and the write. The second change uses a different encoding and takes effect after the write. The read and the write can therefore hit different addresses, and the pointer that comes back has had both changes applied.

The surrounding core samples the operands on a start strobe. The operands are the Z field (pointer select plus modify code), the half select, the pointer register file, the two stride registers and the current Y. The core then sees a read cycle and a write cycle on the synchronous data-memory port. In the cycle after those two, a done pulse comes with the new Y and the final pointer value, plus the index of the pointer register to update.

Top module: `ptr_swap_unit`

## Requirements
- R1: After a synchronous active-high reset, busy, done, mem_re and mem_we are 0, and y_out, ptr_wb_data, ptr_wb_idx and mem_addr are 0.
- R2: A start seen while idle is accepted. In the next cycle mem_re is 1 for exactly one cycle, with mem_addr equal to pointer p = z_field[3:2]. That pointer is taken from ptr_bus[16p+15:16p].
- R3: In the cycle after the read cycle, mem_we is 1 for exactly one cycle and mem_addr holds the pointer after the first modify.
- R4: The first modify uses z_field[1:0]: 00 keeps the pointer, 01 adds 1, 10 subtracts 1, 11 adds j_step.
- R5: The second modify uses z_field[1:0] and is applied to the first-modified pointer: 00 adds 1, 01 keeps it, 10 adds 2, 11 adds k_step. The result appears on ptr_wb_data, with ptr_wb_idx equal to z_field[3:2], in the cycle after the write cycle.
- R6: With x_sel=0, bits 15:0 of y_out take the read word. With x_sel=1, bits 31:16 take it. The other half keeps the value y_in had when start was accepted. y_out is valid in the done cycle and holds afterwards.
- R7: mem_wdata in the write cycle equals the half of y_in selected by x_sel, as sampled when start was accepted.
- R8: All pointer arithmetic wraps modulo 2^16, and j_step and k_step act as 16-bit two's-complement values.
- R9: A start asserted while busy is ignored, and changes to the operand inputs after acceptance have no effect on the running operation.
- R10: busy is 1 in the read and write cycles only. done is a one-cycle pulse in the cycle after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| z_field | input | 4 | Bits 3:2 pointer select, bits 1:0 modify code |
| x_sel | input | 1 | Y half select: 0 low, 1 high |
| ptr_bus | input | 64 | Pointer register file, pointer i in bits 16i+15:16i |
| j_step | input | 16 | Stride used by first modify code 11 |
| k_step | input | 16 | Stride used by second modify code 11 |
| y_in | input | 32 | Current Y value |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_re |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| y_out | output | 32 | Updated Y value |
| ptr_wb_idx | output | 2 | Index of the pointer to update |
| ptr_wb_data | output | 16 | Final pointer value |
| mem_addr | output | 16 | Data-memory address |
| mem_re | output | 1 | Data-memory read strobe |
| mem_we | output | 1 | Data-memory write strobe |
| mem_wdata | output | 16 | Data-memory write data |

## Verification
Every combination of modify code and half select is driven with each of the four pointer registers. Because the two encodings differ per code, a swapped or shared modify table shows up as a wrong write address or a wrong final pointer. Pointers near 0000 and FFFF and negative strides show whether the arithmetic wraps and whether the strides are sign-correct. A start held high during the busy cycles, with different operands on the inputs, shows whether the block re-samples or restarts. Random operations check that the read word lands in the chosen half and that the old half is the word written back.

// File: rtl/ptr_swap_pkg.sv
package ptr_swap_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RD   = 2'd1,
    PH_WR   = 2'd2
  } phase_e;
endpackage

// File: rtl/psw_step.sv
module psw_step #(
  parameter int AW          = 16,
  parameter bit AFTER_WRITE = 1'b0
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [1:0]    code_i,
  input  logic [AW-1:0] stride_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  generate
    if (!AFTER_WRITE) begin : g_pre
      always_comb begin
        case (code_i)
          2'b00:   ptr_o = ptr_i;
          2'b01:   ptr_o = ptr_i + ONE;
          2'b10:   ptr_o = ptr_i - ONE;
          default: ptr_o = ptr_i + stride_i;
        endcase
      end
    end else begin : g_post
      always_comb begin
        case (code_i)
          2'b00:   ptr_o = ptr_i + ONE;
          2'b01:   ptr_o = ptr_i;
          2'b10:   ptr_o = ptr_i + TWO;
          default: ptr_o = ptr_i + stride_i;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/psw_half_mux.sv
module psw_half_mux #(
  parameter int DW = 16
) (
  input  logic [2*DW-1:0] y_i,
  input  logic            hi_i,
  input  logic [DW-1:0]   word_i,
  output logic [2*DW-1:0] y_o,
  output logic [DW-1:0]   old_o
);
  always_comb begin
    y_o   = y_i;
    old_o = y_i[DW-1:0];
    if (hi_i) begin
      old_o          = y_i[2*DW-1:DW];
      y_o[2*DW-1:DW] = word_i;
    end else begin
      y_o[DW-1:0] = word_i;
    end
  end
endmodule

// File: rtl/psw_seq.sv
module psw_seq
  import ptr_swap_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic accept_o,
  output logic rd_o,
  output logic wr_o,
  output logic fin_o,
  output logic busy_o
);
  phase_e ph_q;
  logic   fin_q;

  assign accept_o = start_i && (ph_q == PH_IDLE);
  assign rd_o     = (ph_q == PH_RD);
  assign wr_o     = (ph_q == PH_WR);
  assign busy_o   = (ph_q != PH_IDLE);
  assign fin_o    = fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      fin_q <= 1'b0;
    end else begin
      fin_q <= (ph_q == PH_WR);
      case (ph_q)
        PH_IDLE: if (start_i) ph_q <= PH_RD;
        PH_RD:   ph_q <= PH_WR;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R3
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
    rd_o |=> wr_o && !rd_o);

  // R10
  wr_then_fin_chk: assert property (@(posedge clk) disable iff (rst)
    wr_o |=> fin_o && !wr_o);

  // R10
  fin_single_chk: assert property (@(posedge clk) disable iff (rst)
    fin_o |=> !fin_o);
endmodule

// File: rtl/ptr_swap_unit.sv
module ptr_swap_unit
  import ptr_swap_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int SEL_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [SEL_W+1:0]         z_field,
  input  logic                     x_sel,
  input  logic [(AW<<SEL_W)-1:0]   ptr_bus,
  input  logic [AW-1:0]            j_step,
  input  logic [AW-1:0]            k_step,
  input  logic [2*DW-1:0]          y_in,
  input  logic [DW-1:0]            mem_rdata,
  output logic                     busy,
  output logic                     done,
  output logic [2*DW-1:0]          y_out,
  output logic [SEL_W-1:0]         ptr_wb_idx,
  output logic [AW-1:0]            ptr_wb_data,
  output logic [AW-1:0]            mem_addr,
  output logic                     mem_re,
  output logic                     mem_we,
  output logic [DW-1:0]            mem_wdata
);
  localparam int NPTR = 1 << SEL_W;
  localparam int ZW   = SEL_W + 2;
  localparam int YW   = 2 * DW;

  logic [AW-1:0]    ptr_arr [NPTR];
  logic [AW-1:0]    ptr_pick;
  logic             accept, rd_ph, wr_ph, fin;

  logic [SEL_W-1:0] sel_q;
  logic [1:0]       code_q;
  logic             xsel_q;
  logic [YW-1:0]    y_q;
  logic [AW-1:0]    j_q, k_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [YW-1:0]    y_out_q;
  logic [AW-1:0]    wb_data_q;
  logic [SEL_W-1:0] wb_idx_q;

  logic [AW-1:0]    ptr_mid, ptr_fin;
  logic [YW-1:0]    y_merge;
  logic [DW-1:0]    old_half;

  generate
    for (genvar g = 0; g < NPTR; g++) begin : g_unpack
      assign ptr_arr[g] = ptr_bus[g*AW +: AW];
    end
  endgenerate

  assign ptr_pick = ptr_arr[z_field[ZW-1:2]];

  psw_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .accept_o (accept),
    .rd_o     (rd_ph),
    .wr_o     (wr_ph),
    .fin_o    (fin),
    .busy_o   (busy)
  );

  psw_step #(.AW(AW), .AFTER_WRITE(1'b0)) u_pre (
    .ptr_i    (addr_q),
    .code_i   (code_q),
    .stride_i (j_q),
    .ptr_o    (ptr_mid)
  );

  psw_step #(.AW(AW), .AFTER_WRITE(1'b1)) u_post (
    .ptr_i    (addr_q),
    .code_i   (code_q),
    .stride_i (k_q),
    .ptr_o    (ptr_fin)
  );

  psw_half_mux #(.DW(DW)) u_half (
    .y_i    (y_q),
    .hi_i   (xsel_q),
    .word_i (mem_rdata),
    .y_o    (y_merge),
    .old_o  (old_half)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      code_q    <= '0;
      xsel_q    <= 1'b0;
      y_q       <= '0;
      j_q       <= '0;
      k_q       <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      y_out_q   <= '0;
      wb_data_q <= '0;
      wb_idx_q  <= '0;
    end else begin
      if (accept) begin
        sel_q  <= z_field[ZW-1:2];
        code_q <= z_field[1:0];
        xsel_q <= x_sel;
        y_q    <= y_in;
        j_q    <= j_step;
        k_q    <= k_step;
        addr_q <= ptr_pick;
      end
      if (rd_ph) begin
        addr_q  <= ptr_mid;
        wdata_q <= old_half;
      end
      if (wr_ph) begin
        y_out_q   <= y_merge;
        wb_data_q <= ptr_fin;
        wb_idx_q  <= sel_q;
      end
    end
  end

  assign mem_re      = rd_ph;
  assign mem_we      = wr_ph;
  assign mem_addr    = addr_q;
  assign mem_wdata   = wdata_q;
  assign done        = fin;
  assign y_out       = y_out_q;
  assign ptr_wb_data = wb_data_q;
  assign ptr_wb_idx  = wb_idx_q;

  // R2
  rd_addr_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> mem_re && (mem_addr == $past(ptr_pick)));

  // R4
  pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_re && code_q == 2'b00) |=> mem_addr == $past(mem_addr));

  // R5
  post_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && code_q == 2'b01) |=> ptr_wb_data == $past(mem_addr));

  // R6
  keep_half_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !xsel_q) |-> y_out[YW-1:DW] == y_q[YW-1:DW]);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(code_q) && $stable(sel_q) && $stable(y_q));
endmodule

// File: tb/ptr_swap_unit_tb.sv
`timescale 1ns/1ps
module ptr_swap_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [3:0]  z_field;
  logic        x_sel;
  logic [63:0] ptr_bus;
  logic [15:0] j_step, k_step;
  logic [31:0] y_in;
  logic [15:0] mem_rdata;
  logic        busy, done, mem_re, mem_we;
  logic [31:0] y_out;
  logic [1:0]  ptr_wb_idx;
  logic [15:0] ptr_wb_data, mem_addr, mem_wdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  ptr_swap_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .z_field(z_field), .x_sel(x_sel),
    .ptr_bus(ptr_bus), .j_step(j_step), .k_step(k_step), .y_in(y_in),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .y_out(y_out),
    .ptr_wb_idx(ptr_wb_idx), .ptr_wb_data(ptr_wb_data), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  always_ff @(posedge clk) begin
    if (mem_re) mem_rdata <= mem_word(mem_addr);
  end

  function automatic logic [15:0] exp_pre(input logic [15:0] p, input logic [1:0] c,
                                          input logic [15:0] j);
    case (c)
      2'b00:   return p;
      2'b01:   return p + 16'd1;
      2'b10:   return p - 16'd1;
      default: return p + j;
    endcase
  endfunction

  function automatic logic [15:0] exp_post(input logic [15:0] p, input logic [1:0] c,
                                           input logic [15:0] k);
    case (c)
      2'b00:   return p + 16'd1;
      2'b01:   return p;
      2'b10:   return p + 16'd2;
      default: return p + k;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] sel, input logic [1:0] code, input bit xs,
                        input logic [31:0] y, input logic [15:0] j, input logic [15:0] k,
                        input logic [63:0] ptrs, input bit poke_busy);
    logic [15:0] p0, p1, p2, rd, oldh;
    logic [31:0] ynew;
    p0   = ptrs[sel*16 +: 16];
    p1   = exp_pre(p0, code, j);
    p2   = exp_post(p1, code, k);
    rd   = mem_word(p0);
    oldh = xs ? y[31:16] : y[15:0];
    ynew = xs ? {rd, y[15:0]} : {y[31:16], rd};

    @(negedge clk);
    z_field = {sel, code}; x_sel = xs; y_in = y;
    j_step = j; k_step = k; ptr_bus = ptrs; start = 1'b1;

    @(negedge clk);
    chk(mem_re && !mem_we && busy, "R2 read strobe", {29'd0, mem_re, mem_we, busy}, 32'd5);
    chk(mem_addr == p0, "R2 read address", {16'd0, mem_addr}, {16'd0, p0});
    if (poke_busy) begin
      start = 1'b1; z_field = ~z_field; x_sel = ~xs; y_in = ~y;
      ptr_bus = ~ptrs; j_step = ~j; k_step = ~k;
    end else begin
      start = 1'b0;
    end

    @(negedge clk);
    start = 1'b0;
    chk(mem_we && !mem_re && busy, "R3 write strobe", {29'd0, mem_re, mem_we, busy}, 32'd3);
    chk(mem_addr == p1, "R4 R8 write address", {16'd0, mem_addr}, {16'd0, p1});
    chk(mem_wdata == oldh, "R7 write data", {16'd0, mem_wdata}, {16'd0, oldh});

    @(negedge clk);
    chk(done && !busy && !mem_we, "R10 done pulse", {30'd0, done, busy}, 32'd2);
    chk(ptr_wb_data == p2, "R5 R8 final pointer", {16'd0, ptr_wb_data}, {16'd0, p2});
    chk(ptr_wb_idx == sel, "R5 pointer index", {30'd0, ptr_wb_idx}, {30'd0, sel});
    chk(y_out == ynew, "R6 y result", y_out, ynew);
    if (poke_busy) chk(y_out == ynew && ptr_wb_data == p2, "R9 busy start ignored",
                       {16'd0, ptr_wb_data}, {16'd0, p2});

    @(negedge clk);
    chk(!done && !busy && !mem_re, "R10 idle after done", {30'd0, done, busy}, 32'd0);
    chk(y_out == ynew, "R6 y holds", y_out, ynew);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst = 1'b1; start = 1'b0; z_field = '0; x_sel = 1'b0; ptr_bus = '0;
    j_step = '0; k_step = '0; y_in = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_re && !mem_we, "R1 reset strobes",
        {28'd0, busy, done, mem_re, mem_we}, 32'd0);
    chk(y_out == 0 && ptr_wb_data == 0 && mem_addr == 0 && ptr_wb_idx == 0,
        "R1 reset data", y_out, 32'd0);
    rst = 1'b0;

    // R4 R5 R6: every code and half with every pointer register
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 4; c++)
        for (int x = 0; x < 2; x++)
          run_op(2'(s), 2'(c), x[0], 32'hA1B2_C3D4, 16'h0010, 16'hFFF0,
                 64'h4000_3000_2000_1000, 1'b0);

    // R8 wrap corners
    run_op(2'd0, 2'b01, 1'b0, 32'h1111_2222, 16'd0, 16'd0, 64'h0000_0000_0000_FFFF, 1'b0);
    run_op(2'd1, 2'b10, 1'b1, 32'h3333_4444, 16'd0, 16'd0, 64'h0000_0000_0000_0000, 1'b0);
    run_op(2'd2, 2'b11, 1'b0, 32'h5555_6666, 16'hFFFE, 16'h8000, 64'h0000_0001_0000_0000, 1'b0);
    run_op(2'd3, 2'b10, 1'b1, 32'h7777_8888, 16'd0, 16'd0, 64'hFFFF_0000_0000_0000, 1'b0);
    run_op(2'd3, 2'b00, 1'b0, 32'h9999_AAAA, 16'd0, 16'd0, 64'hFFFF_0000_0000_0000, 1'b0);

    // R9 start held while busy with altered operands
    run_op(2'd1, 2'b11, 1'b0, 32'hDEAD_BEEF, 16'h0003, 16'hFFFD, 64'h0123_4567_89AB_CDEF, 1'b1);
    run_op(2'd2, 2'b01, 1'b1, 32'hCAFE_F00D, 16'h0100, 16'h0200, 64'h0123_4567_89AB_CDEF, 1'b1);

    // random operations
    for (int n = 0; n < 200; n++)
      run_op(2'($urandom), 2'($urandom), 1'($urandom), $urandom,
             16'($urandom), 16'($urandom), {$urandom, $urandom}, (n % 17) == 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule